// File: doc/BRIEF.md
# Debug Event Dispatcher

This block is the run-state controller of a small management core. A host raises debug events by setting bits in a 16-bit pending word. While the core is running, the controller examines that word once per clock cycle, which counts as one run-loop iteration. It acts on the bits it knows in a fixed priority.

Three kinds of bit are recognised:

- **Ordering request.** One bit asks for the memory-ordering policy to be reprogrammed. The controller emits a one-cycle strobe for it and keeps running.
- **Terminal events.** A single-step countdown and two breakpoint kinds halt the core. Each halt carries its own reason code, and the core stays halted until the host resumes it.
- **Unknown bits.** A pending bit with no handler sends the controller into a fatal state. Only reset leaves that state.

The ordering hardware itself and the host register interface sit outside this block. The host reaches the block only through the set, step-load and resume inputs.

Top module: `dbg_evt_dispatch`

## Requirements
- R1: After reset the pending word is zero, `halted`, `fatal`, `halt_strobe` and `order_strobe` are low, and `halt_reason` is 0.
- R2: A one-cycle pulse on `ev_set` ORs its bits into the pending word, which appears on `pending` after the next rising edge. New set bits win over a same-cycle clear of the same bit.
- R3: With bit 9 pending in a running iteration, `order_strobe` is high for exactly the following cycle and bit 9 is cleared. This event is non-terminal: bits 8, 3 and 2 are still evaluated in that same iteration.
- R4: `step_load` writes `step_value` into the step counter. Each running iteration that finds bit 8 pending lowers the counter by one. The iteration that finds the counter at 1 or 0 instead halts with reason 64, clears bit 8 and leaves the counter at 0. A load of N therefore halts on the Nth iteration, and a load of 0 halts on the first.
- R5: Bit 3 pending, with no step halt in that iteration, halts with reason 8 and clears bit 3.
- R6: Bit 2 pending, with neither a step halt nor bit 3 in that iteration, halts with reason 4 and clears bit 2.
- R7: Priority runs bit 9, bit 8, bit 3, bit 2. At most one terminal halt is taken per iteration. Every lower-priority bit stays pending, unprocessed, until the core is resumed.
- R8: A running iteration that takes no terminal halt and finds any pending bit outside {9, 8, 3, 2} enters the fatal state. `fatal` then stays high until reset, `resume` is ignored, and no further strobes are produced.
- R9: While halted, no bit is dispatched, the step counter does not move, and `halt_reason` holds its value. A `resume` pulse clears `halt_reason` to 0 and returns the core to running after the next edge.
- R10: `halt_strobe` is high for exactly the cycle in which `halted` first goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set | input | 16 | Host event bits to OR into the pending word |
| step_load | input | 1 | Load `step_value` into the step counter |
| step_value | input | 8 | Single-step count |
| resume | input | 1 | Leave the halted state |
| pending | output | 16 | Current pending event word |
| order_strobe | output | 1 | Ordering-policy reprogram request pulse |
| halt_strobe | output | 1 | Pulse when a halt is taken |
| halt_reason | output | 8 | Reason code of the current halt, 0 when not halted |
| halted | output | 1 | Core halted |
| fatal | output | 1 | Fatal spin state entered |

## Verification
The bench builds the block with its default configuration: a 16-bit event word, an 8-bit step counter and the bit positions and reason codes above.

It sweeps all sixteen combinations of the four handled bits against step loads of 0, 1 and 3. This exercises every ordering of the ordering strobe, countdown and breakpoint halts, including lower bits left pending across resumes.

Every unhandled bit position is then tried alone and behind a breakpoint, which shows that fatal escalation waits for the halt to be resumed. The bench also re-raises a bit in the same cycle it is consumed.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HALT  = 2'd1,
      ST_FATAL = 2'd2
   } run_st_e;

endpackage

// File: rtl/dbg_evt_word.sv
module dbg_evt_word #(
   parameter int EVT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] set_i,
   input  logic [EVT_W-1:0] clr_i,
   output logic [EVT_W-1:0] evt_o
);

   // One flop per event bit; a set in the same cycle as a clear keeps the bit.
   for (genvar b = 0; b < EVT_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)         evt_o[b] <= 1'b0;
         else if (set_i[b])  evt_o[b] <= 1'b1;
         else if (clr_i[b])  evt_o[b] <= 1'b0;
      end
   end

endmodule

// File: rtl/dbg_step_ctr.sv
module dbg_step_ctr #(
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [STEP_W-1:0] load_val_i,
   input  logic              dec_i,
   input  logic              zero_i,
   output logic              last_o
);

   localparam logic [STEP_W-1:0] CNT_ONE = STEP_W'(1);

   logic [STEP_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load_i)  cnt_q <= load_val_i;
      else if (zero_i)  cnt_q <= '0;
      else if (dec_i)   cnt_q <= cnt_q - CNT_ONE;
   end

   // A count of one or zero means the next step iteration is the final one.
   assign last_o = (cnt_q <= CNT_ONE);

endmodule

// File: rtl/dbg_evt_fsm.sv
module dbg_evt_fsm
   import dbg_evt_pkg::*;
#(
   parameter int EVT_W    = 16,
   parameter int RSN_W    = 8,
   parameter int ORD_BIT  = 9,
   parameter int STEP_BIT = 8,
   parameter int XBRK_BIT = 3,
   parameter int IBRK_BIT = 2,
   parameter int STEP_RSN = 64,
   parameter int XBRK_RSN = 8,
   parameter int IBRK_RSN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic             step_last_i,
   input  logic             resume_i,
   output logic [EVT_W-1:0] clr_o,
   output logic             step_dec_o,
   output logic             step_zero_o,
   output logic             halt_strobe_o,
   output logic [RSN_W-1:0] halt_reason_o,
   output logic             halted_o,
   output logic             order_strobe_o,
   output logic             fatal_o
);

   localparam logic [EVT_W-1:0] ONE    = EVT_W'(1);
   localparam logic [EVT_W-1:0] M_ORD  = ONE << ORD_BIT;
   localparam logic [EVT_W-1:0] M_STEP = ONE << STEP_BIT;
   localparam logic [EVT_W-1:0] M_XBRK = ONE << XBRK_BIT;
   localparam logic [EVT_W-1:0] M_IBRK = ONE << IBRK_BIT;
   localparam logic [EVT_W-1:0] M_KNOWN = M_ORD | M_STEP | M_XBRK | M_IBRK;

   run_st_e          st_q, st_d;
   logic [RSN_W-1:0] rsn_d;
   logic             running;
   logic             ord_hit, step_hit, step_fin, xb_hit, ib_hit;
   logic             term_hit, unk_hit;

   assign running = (st_q == ST_RUN);

   // Fixed-priority evaluation of one run-loop iteration.
   always_comb begin
      ord_hit  = running & evt_i[ORD_BIT];
      step_hit = running & evt_i[STEP_BIT];
      step_fin = step_hit & step_last_i;
      xb_hit   = running & evt_i[XBRK_BIT] & ~step_fin;
      ib_hit   = running & evt_i[IBRK_BIT] & ~step_fin & ~evt_i[XBRK_BIT];
      term_hit = step_fin | xb_hit | ib_hit;
      unk_hit  = running & ~term_hit & (|(evt_i & ~M_KNOWN));
   end

   assign clr_o = ({EVT_W{ord_hit}}  & M_ORD)
                | ({EVT_W{step_fin}} & M_STEP)
                | ({EVT_W{xb_hit}}   & M_XBRK)
                | ({EVT_W{ib_hit}}   & M_IBRK);

   assign step_dec_o  = step_hit & ~step_fin;
   assign step_zero_o = step_fin;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN: begin
            if (term_hit)      st_d = ST_HALT;
            else if (unk_hit)  st_d = ST_FATAL;
         end
         ST_HALT: begin
            if (resume_i)      st_d = ST_RUN;
         end
         default:              st_d = ST_FATAL;
      endcase
   end

   always_comb begin
      rsn_d = halt_reason_o;
      if (step_fin)                         rsn_d = RSN_W'(STEP_RSN);
      else if (xb_hit)                      rsn_d = RSN_W'(XBRK_RSN);
      else if (ib_hit)                      rsn_d = RSN_W'(IBRK_RSN);
      else if (st_q == ST_HALT && resume_i) rsn_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q           <= ST_RUN;
         halt_reason_o  <= '0;
         halt_strobe_o  <= 1'b0;
         order_strobe_o <= 1'b0;
      end else begin
         st_q           <= st_d;
         halt_reason_o  <= rsn_d;
         halt_strobe_o  <= term_hit;
         order_strobe_o <= ord_hit;
      end
   end

   assign halted_o = (st_q == ST_HALT);
   assign fatal_o  = (st_q == ST_FATAL);

endmodule

// File: rtl/dbg_evt_dispatch.sv
module dbg_evt_dispatch #(
   parameter int EVT_W    = 16,
   parameter int STEP_W   = 8,
   parameter int RSN_W    = 8,
   parameter int ORD_BIT  = 9,
   parameter int STEP_BIT = 8,
   parameter int XBRK_BIT = 3,
   parameter int IBRK_BIT = 2,
   parameter int STEP_RSN = 64,
   parameter int XBRK_RSN = 8,
   parameter int IBRK_RSN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  ev_set,
   input  logic              step_load,
   input  logic [STEP_W-1:0] step_value,
   input  logic              resume,
   output logic [EVT_W-1:0]  pending,
   output logic              order_strobe,
   output logic              halt_strobe,
   output logic [RSN_W-1:0]  halt_reason,
   output logic              halted,
   output logic              fatal
);

   localparam int RSN_LIM = 1 << RSN_W;

   // Elaboration-time parameter checks
   if (EVT_W < 2 || STEP_W < 1 || RSN_W < 1) begin : g_bad_width
      $error("dbg_evt_dispatch: width parameters too small");
   end
   if (ORD_BIT >= EVT_W || STEP_BIT >= EVT_W ||
       XBRK_BIT >= EVT_W || IBRK_BIT >= EVT_W) begin : g_bad_pos
      $error("dbg_evt_dispatch: event bit outside the event word");
   end
   if (ORD_BIT == STEP_BIT || ORD_BIT == XBRK_BIT || ORD_BIT == IBRK_BIT ||
       STEP_BIT == XBRK_BIT || STEP_BIT == IBRK_BIT ||
       XBRK_BIT == IBRK_BIT) begin : g_bad_dup
      $error("dbg_evt_dispatch: event bit positions must differ");
   end
   if (STEP_RSN >= RSN_LIM || XBRK_RSN >= RSN_LIM || IBRK_RSN >= RSN_LIM ||
       STEP_RSN == 0 || XBRK_RSN == 0 || IBRK_RSN == 0) begin : g_bad_rsn
      $error("dbg_evt_dispatch: reason code zero or too wide");
   end

   logic [EVT_W-1:0] evt_clr;
   logic             step_last, step_dec, step_zero;

   dbg_evt_word #(.EVT_W(EVT_W)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_set),
      .clr_i (evt_clr),
      .evt_o (pending)
   );

   dbg_step_ctr #(.STEP_W(STEP_W)) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (step_load),
      .load_val_i (step_value),
      .dec_i      (step_dec),
      .zero_i     (step_zero),
      .last_o     (step_last)
   );

   dbg_evt_fsm #(
      .EVT_W    (EVT_W),
      .RSN_W    (RSN_W),
      .ORD_BIT  (ORD_BIT),
      .STEP_BIT (STEP_BIT),
      .XBRK_BIT (XBRK_BIT),
      .IBRK_BIT (IBRK_BIT),
      .STEP_RSN (STEP_RSN),
      .XBRK_RSN (XBRK_RSN),
      .IBRK_RSN (IBRK_RSN)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .evt_i          (pending),
      .step_last_i    (step_last),
      .resume_i       (resume),
      .clr_o          (evt_clr),
      .step_dec_o     (step_dec),
      .step_zero_o    (step_zero),
      .halt_strobe_o  (halt_strobe),
      .halt_reason_o  (halt_reason),
      .halted_o       (halted),
      .order_strobe_o (order_strobe),
      .fatal_o        (fatal)
   );

endmodule

// File: rtl/dbg_evt_dispatch_chk.sv
module dbg_evt_dispatch_chk #(
   parameter int RSN_W    = 8,
   parameter int STEP_RSN = 64,
   parameter int XBRK_RSN = 8,
   parameter int IBRK_RSN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             resume,
   input logic             order_strobe,
   input logic             halt_strobe,
   input logic [RSN_W-1:0] halt_reason,
   input logic             halted,
   input logic             fatal
);

   a_r8_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> fatal);

   a_r8_fatal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal && $past(fatal)) |-> (!halt_strobe && !order_strobe && !halted));

   a_r8_state_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({halted, fatal}));

   a_r10_strobe_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
      halt_strobe |-> halted);

   a_r10_rise_strobed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> halt_strobe);

   a_r9_reason_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !resume) |=> (halted && $stable(halt_reason)));

   a_r9_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && resume) |=> (!halted && halt_reason == '0));

   // R4, R5, R6: only the three defined reason codes accompany a halt
   a_r5_reason_legal: assert property (@(posedge clk) disable iff (!rst_n)
      halt_strobe |-> (halt_reason == RSN_W'(STEP_RSN) ||
                       halt_reason == RSN_W'(XBRK_RSN) ||
                       halt_reason == RSN_W'(IBRK_RSN)));

endmodule

bind dbg_evt_dispatch dbg_evt_dispatch_chk #(
   .RSN_W    (RSN_W),
   .STEP_RSN (STEP_RSN),
   .XBRK_RSN (XBRK_RSN),
   .IBRK_RSN (IBRK_RSN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .resume       (resume),
   .order_strobe (order_strobe),
   .halt_strobe  (halt_strobe),
   .halt_reason  (halt_reason),
   .halted       (halted),
   .fatal        (fatal)
);

// File: tb/tb_dbg_evt_dispatch.sv
module tb_dbg_evt_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ev_set = '0;
   logic        step_load = 1'b0;
   logic [7:0]  step_value = '0;
   logic        resume = 1'b0;
   logic [15:0] pending;
   logic        order_strobe, halt_strobe, halted, fatal;
   logic [7:0]  halt_reason;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   dbg_evt_dispatch dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_set       (ev_set),
      .step_load    (step_load),
      .step_value   (step_value),
      .resume       (resume),
      .pending      (pending),
      .order_strobe (order_strobe),
      .halt_strobe  (halt_strobe),
      .halt_reason  (halt_reason),
      .halted       (halted),
      .fatal        (fatal)
   );

   // Reference state, kept from the requirements
   logic [15:0] m_evt;
   logic [7:0]  m_cnt;
   int          m_mode;   // 0 running, 1 halted, 2 fatal
   logic [7:0]  m_rsn;
   logic        m_hs, m_os;

   task automatic compare(input string tag);
      n_tests++;
      if (pending !== m_evt || order_strobe !== m_os || halt_strobe !== m_hs ||
          halt_reason !== m_rsn || halted !== (m_mode == 1) || fatal !== (m_mode == 2)) begin
         n_fail++;
         $display("FAIL %s: actual pend=%h os=%b hs=%b rsn=%0d hlt=%b fat=%b expected pend=%h os=%b hs=%b rsn=%0d hlt=%b fat=%b",
                  tag, pending, order_strobe, halt_strobe, halt_reason, halted, fatal,
                  m_evt, m_os, m_hs, m_rsn, (m_mode == 1), (m_mode == 2));
      end
   endtask

   // One clock: drive at the falling edge, model the rising edge, sample at the next falling edge.
   task automatic tick(input logic [15:0] set, input logic ld, input logic [7:0] val,
                       input logic rs, input string tag);
      logic [15:0] keep;
      logic [7:0]  cnt_n;
      int          mode_n;
      ev_set = set; step_load = ld; step_value = val; resume = rs;
      @(posedge clk);
      keep   = m_evt;
      cnt_n  = m_cnt;
      mode_n = m_mode;
      m_hs   = 1'b0;
      m_os   = 1'b0;
      if (m_mode == 0) begin
         if (m_evt[9]) begin
            m_os = 1'b1;
            keep[9] = 1'b0;
         end
         if (m_evt[8] && (m_cnt == 8'd0 || m_cnt == 8'd1)) begin
            m_hs = 1'b1; m_rsn = 8'd64; keep[8] = 1'b0; cnt_n = 8'd0; mode_n = 1;
         end else begin
            if (m_evt[8]) cnt_n = m_cnt - 8'd1;
            if (m_evt[3]) begin
               m_hs = 1'b1; m_rsn = 8'd8; keep[3] = 1'b0; mode_n = 1;
            end else if (m_evt[2]) begin
               m_hs = 1'b1; m_rsn = 8'd4; keep[2] = 1'b0; mode_n = 1;
            end else if ((m_evt & 16'hFCF3) != 16'h0) begin
               mode_n = 2;
            end
         end
      end else if (m_mode == 1 && rs) begin
         mode_n = 0;
         m_rsn  = 8'd0;
      end
      m_evt  = keep | set;
      m_cnt  = ld ? val : cnt_n;
      m_mode = mode_n;
      @(negedge clk);
      ev_set = '0; step_load = 1'b0; resume = 1'b0;
      compare(tag);
   endtask

   task automatic do_reset();
      ev_set = '0; step_load = 1'b0; step_value = '0; resume = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_evt = '0; m_cnt = '0; m_mode = 0; m_rsn = '0; m_hs = 1'b0; m_os = 1'b0;
      compare("R1");
   endtask

   function automatic string tag_of(input logic [15:0] m);
      if ((m & 16'hFCF3) != 0) return "R8";
      if (m[9] && (m[8] || m[3] || m[2])) return "R3/R7";
      if ((m[8] + m[3] + m[2]) > 1) return "R7/R9/R10";
      if (m[9]) return "R3";
      if (m[8]) return "R4";
      if (m[3]) return "R5";
      if (m[2]) return "R6";
      return "R2";
   endfunction

   // Inject a mask after a step load, then run iterations, resuming every third cycle while halted.
   task automatic run_case(input logic [15:0] mask, input logic [7:0] stepv);
      string t;
      t = tag_of(mask);
      do_reset();
      tick('0, 1'b1, stepv, 1'b0, "R4");
      tick(mask, 1'b0, 8'd0, 1'b0, "R2");
      for (int i = 0; i < 14; i++)
         tick('0, 1'b0, 8'd0, (i % 3 == 2), t);
   endtask

   initial begin : watchdog
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      do_reset();

      // All combinations of the four handled bits, several step counts (R3 R4 R5 R6 R7 R9 R10)
      for (int c = 0; c < 16; c++) begin
         for (int s = 0; s < 3; s++) begin
            logic [15:0] mk;
            mk = {6'd0, c[3], c[2], 4'd0, c[1], c[0], 2'd0};
            run_case(mk, (s == 0) ? 8'd0 : (s == 1) ? 8'd1 : 8'd3);
         end
      end

      // Each unhandled bit alone, and behind an external breakpoint (R8, R7)
      for (int b = 0; b < 16; b++) begin
         if (b != 9 && b != 8 && b != 3 && b != 2) begin
            run_case(16'h1 << b, 8'd2);
            run_case((16'h1 << b) | 16'h0008, 8'd2);
            run_case((16'h1 << b) | 16'h0200, 8'd2);
         end
      end

      // R11-style collision: bit 3 re-raised in the cycle it is consumed stays pending (R2)
      do_reset();
      tick(16'h000C, 1'b0, 8'd0, 1'b0, "R2");
      tick(16'h0008, 1'b0, 8'd0, 1'b0, "R2");
      tick('0, 1'b0, 8'd0, 1'b1, "R9");
      tick('0, 1'b0, 8'd0, 1'b0, "R5");
      tick('0, 1'b0, 8'd0, 1'b1, "R9");
      tick('0, 1'b0, 8'd0, 1'b0, "R6");

      // Step held while halted: counter must not move (R9, R4)
      do_reset();
      tick('0, 1'b1, 8'd3, 1'b0, "R4");
      tick(16'h0108, 1'b0, 8'd0, 1'b0, "R2");
      for (int i = 0; i < 4; i++) tick('0, 1'b0, 8'd0, 1'b0, "R9");
      tick('0, 1'b0, 8'd0, 1'b1, "R9");
      for (int i = 0; i < 4; i++) tick('0, 1'b0, 8'd0, 1'b0, "R4");

      // Fatal ignores resume and later events (R8)
      do_reset();
      tick(16'h8000, 1'b0, 8'd0, 1'b0, "R8");
      tick('0, 1'b0, 8'd0, 1'b0, "R8");
      tick(16'h020C, 1'b0, 8'd0, 1'b1, "R8");
      tick('0, 1'b0, 8'd0, 1'b1, "R8");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule